// File: doc/BRIEF.md
# Daisy-Chained Priority Request Cell

This cell is the interrupt-priority logic that one peripheral uses on a shared I/O bus where priority is set by position along a chain. The bus has four request levels. Each level has its own permission signal. That signal starts at the processor side, enters the cell on `en_in` and leaves on `en_out` toward the devices further down the chain. Level 0 is the most urgent and level 3 the least urgent. One instance serves one level, chosen by the `LEVEL` parameter. It passes the other three permission signals through untouched.

When the peripheral raises its service flag, the cell posts a request on its level at the next I/O clock tick, but only if the incoming permission for that level is true at that tick. From the moment the request is registered, the outgoing permission for that level is forced low. This combinational cut stops every device below from posting, which settles any tie among devices that request at the same tick. When the processor grants the break, the cell drives its trap address onto the shared input address bus until the grant ends. It then withdraws its request and waits for the peripheral to drop the flag before it can post again. A synchronous system clear returns the cell to idle.

Top module: `drl_prio_cell`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `req_out` = 0, `addr_drive` = 0 and `addr_out` = 0.
- R2: A request appears on `req_out[LEVEL]` in the cycle after an edge at which `io_tick`, `svc_flag` and `en_in[LEVEL]` are all high, and at no other time from idle.
- R3: If `en_in[LEVEL]` is low at the tick, no request is posted, even with `svc_flag` high.
- R4: `en_out[LEVEL]` equals `en_in[LEVEL]` AND NOT `req_out[LEVEL]`, combinationally. Every other bit of `en_out` equals the same bit of `en_in`.
- R5: Only bit `LEVEL` of `req_out` is ever high.
- R6: A posted request seen together with a high `grant` at an edge sets `addr_drive` in the next cycle. While `addr_drive` is high, `addr_out` equals `TRAP_ADDR`; otherwise `addr_out` is 0.
- R7: If `grant` is low at an edge during the break, both `req_out[LEVEL]` and `addr_drive` are low in the next cycle.
- R8: If `svc_flag` is low at an edge while a request or a break is active, both are removed in the next cycle.
- R9: After a break ends with `svc_flag` still high, no new request is posted until an edge at which `svc_flag` is seen low.
- R10: Once posted, a request stays up regardless of `en_in` and `io_tick` until R7 or R8 removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system clear |
| io_tick | input | 1 | One-cycle strobe marking the I/O clock pulse |
| svc_flag | input | 1 | Peripheral wants service |
| en_in | input | NLEV | Permission chain from upstream, one bit per level |
| en_out | output | NLEV | Permission chain to downstream devices |
| req_out | output | NLEV | Request lines, one bit per level |
| grant | input | 1 | Processor grants the break (level) |
| addr_drive | output | 1 | Cell is driving the address bus |
| addr_out | output | ADDR_W | Trap address during the break, zero otherwise |

## Verification
Requests, the address drive and their removal are registered. Each of these results is due exactly one clock edge after the inputs that cause it. The bench drives inputs on the falling edge, steps its model to the state after the next rising edge, and compares at the falling edge after that. The permission chain is combinational, so it is compared 1 ns after the inputs change, before the next rising edge and against the request state that is still current. Directed sequences cover the level-blocked tick, a held request with the permission dropped, the break, and the re-arm lock. Seeded random traffic covers the rest.

// File: rtl/drl_prio_pkg.sv
package drl_prio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POST = 2'd1,
    ST_SERV = 2'd2,
    ST_LOCK = 2'd3
  } cell_st_t;
endpackage

// File: rtl/drl_prio_seq.sv
module drl_prio_seq
  import drl_prio_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic svc,
  input  logic lvl_en,
  input  logic grant,
  output logic posted,
  output logic serving
);
  cell_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (tick && svc && lvl_en) st_d = ST_POST;
      ST_POST: begin
        if (!svc)       st_d = ST_IDLE;
        else if (grant) st_d = ST_SERV;
      end
      ST_SERV: begin
        if (!svc)        st_d = ST_IDLE;
        else if (!grant) st_d = ST_LOCK;
      end
      ST_LOCK: if (!svc) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign posted  = (st_q == ST_POST) || (st_q == ST_SERV);
  assign serving = (st_q == ST_SERV);
endmodule

// File: rtl/drl_prio_chain.sv
module drl_prio_chain #(
  parameter int NLEV  = 4,
  parameter int LEVEL = 1
) (
  input  logic [NLEV-1:0] en_in,
  input  logic            posted,
  output logic [NLEV-1:0] en_out,
  output logic [NLEV-1:0] req_out
);
  for (genvar g = 0; g < NLEV; g++) begin : g_lvl
    if (g == LEVEL) begin : g_own
      assign en_out[g]  = en_in[g] & ~posted;
      assign req_out[g] = posted;
    end else begin : g_pass
      assign en_out[g]  = en_in[g];
      assign req_out[g] = 1'b0;
    end
  end
endmodule

// File: rtl/drl_prio_vec.sv
module drl_prio_vec #(
  parameter int                ADDR_W    = 15,
  parameter logic [ADDR_W-1:0] TRAP_ADDR = '0
) (
  input  logic              serving,
  output logic              addr_drive,
  output logic [ADDR_W-1:0] addr_out
);
  assign addr_drive = serving;
  assign addr_out   = serving ? TRAP_ADDR : '0;
endmodule

// File: rtl/drl_prio_cell.sv
module drl_prio_cell #(
  parameter int                NLEV      = 4,
  parameter int                LEVEL     = 1,
  parameter int                ADDR_W    = 15,
  parameter logic [ADDR_W-1:0] TRAP_ADDR = 15'h0123
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_tick,
  input  logic              svc_flag,
  input  logic [NLEV-1:0]   en_in,
  output logic [NLEV-1:0]   en_out,
  output logic [NLEV-1:0]   req_out,
  input  logic              grant,
  output logic              addr_drive,
  output logic [ADDR_W-1:0] addr_out
);
  logic posted, serving;

  drl_prio_seq u_seq (
    .clk(clk), .rst(rst), .tick(io_tick), .svc(svc_flag),
    .lvl_en(en_in[LEVEL]), .grant(grant),
    .posted(posted), .serving(serving)
  );

  drl_prio_chain #(.NLEV(NLEV), .LEVEL(LEVEL)) u_chain (
    .en_in(en_in), .posted(posted), .en_out(en_out), .req_out(req_out)
  );

  drl_prio_vec #(.ADDR_W(ADDR_W), .TRAP_ADDR(TRAP_ADDR)) u_vec (
    .serving(serving), .addr_drive(addr_drive), .addr_out(addr_out)
  );
endmodule

// File: rtl/drl_prio_cell_chk.sv
module drl_prio_cell_chk #(
  parameter int                NLEV      = 4,
  parameter int                LEVEL     = 1,
  parameter int                ADDR_W    = 15,
  parameter logic [ADDR_W-1:0] TRAP_ADDR = 15'h0123
) (
  input logic              clk,
  input logic              rst,
  input logic              io_tick,
  input logic              svc_flag,
  input logic [NLEV-1:0]   en_in,
  input logic [NLEV-1:0]   en_out,
  input logic [NLEV-1:0]   req_out,
  input logic              grant,
  input logic              addr_drive,
  input logic [ADDR_W-1:0] addr_out
);
  localparam logic [NLEV-1:0] OWN = NLEV'(1) << LEVEL;

  // R1
  clear_state_chk: assert property (@(posedge clk)
    rst |=> (req_out == '0) && !addr_drive);

  // R2
  post_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_out[LEVEL]) |-> $past(io_tick && svc_flag && en_in[LEVEL]));

  // R4
  chain_cut_chk: assert property (@(posedge clk) disable iff (rst)
    req_out[LEVEL] |-> !en_out[LEVEL]);

  // R5
  own_line_chk: assert property (@(posedge clk) disable iff (rst)
    (req_out & ~OWN) == '0);

  // R6
  trap_value_chk: assert property (@(posedge clk) disable iff (rst)
    addr_drive |-> (addr_out == TRAP_ADDR) && req_out[LEVEL]);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_drive && !grant) |=> !addr_drive && !req_out[LEVEL]);

  // R8
  flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_out[LEVEL] && !svc_flag) |=> !req_out[LEVEL]);
endmodule

bind drl_prio_cell drl_prio_cell_chk #(
  .NLEV(NLEV), .LEVEL(LEVEL), .ADDR_W(ADDR_W), .TRAP_ADDR(TRAP_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .io_tick(io_tick), .svc_flag(svc_flag),
  .en_in(en_in), .en_out(en_out), .req_out(req_out), .grant(grant),
  .addr_drive(addr_drive), .addr_out(addr_out)
);

// File: tb/sim_drl_prio_cell.sv
module sim_drl_prio_cell;
  localparam int NLEV = 4;
  localparam int LVL  = 1;
  localparam int AW   = 15;
  localparam logic [AW-1:0] TRAP = 15'h0123;

  logic clk = 1'b0;
  logic rst, io_tick, svc_flag, grant;
  logic [NLEV-1:0] en_in, en_out, req_out;
  logic addr_drive;
  logic [AW-1:0] addr_out;

  always #10 clk = ~clk;

  drl_prio_cell #(.NLEV(NLEV), .LEVEL(LVL), .ADDR_W(AW), .TRAP_ADDR(TRAP)) u0 (
    .clk(clk), .rst(rst), .io_tick(io_tick), .svc_flag(svc_flag),
    .en_in(en_in), .en_out(en_out), .req_out(req_out), .grant(grant),
    .addr_drive(addr_drive), .addr_out(addr_out)
  );

  int total = 0;
  int bad   = 0;
  bit ended = 0;
  int mst   = 0;   // 0 idle, 1 posted, 2 break, 3 locked
  bit p_svc = 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int next_st(int s, bit r, bit t, bit f, bit e, bit g);
    if (r) return 0;
    case (s)
      0: return (t && f && e) ? 1 : 0;
      1: return !f ? 0 : (g ? 2 : 1);
      2: return !f ? 0 : (!g ? 3 : 2);
      default: return f ? 3 : 0;
    endcase
  endfunction

  function automatic bit req_exp(int s);
    return (s == 1) || (s == 2);
  endfunction

  task automatic step(bit r, bit t, bit f, logic [NLEV-1:0] e, bit g);
    string tag;
    @(negedge clk);
    if (!p_svc && mst == 0) tag = "R8";
    else case (mst)
      0: tag = "R2";
      1: tag = "R10";
      2: tag = "R6";
      default: tag = "R9";
    endcase
    check(tag, 32'(req_out[LVL]), 32'(req_exp(mst)));
    check("R5", 32'(req_out & ~(NLEV'(1) << LVL)), 32'd0);
    check("R6", 32'(addr_drive), 32'(mst == 2));
    check("R6", 32'(addr_out), (mst == 2) ? 32'(TRAP) : 32'd0);
    rst = r; io_tick = t; svc_flag = f; en_in = e; grant = g;
    #1;
    check("R4", 32'(en_out), 32'(e & ~(NLEV'(req_exp(mst)) << LVL)));
    mst = next_st(mst, r, t, f, e[LVL], g);
    p_svc = f;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst = 1; io_tick = 0; svc_flag = 0; en_in = '1; grant = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 32'(req_out), 32'd0);
    check("R1", 32'(addr_drive), 32'd0);
    check("R1", 32'(addr_out), 32'd0);
    mst = 0;
    // R3: permission low at the tick blocks the post
    step(0, 1, 1, 4'b1101, 0);
    step(0, 0, 1, 4'b1111, 0);
    // R2: post, then R10: hold while permission drops and ticks come
    step(0, 1, 1, 4'b1111, 0);
    step(0, 1, 1, 4'b0000, 0);
    step(0, 1, 1, 4'b0101, 0);
    // R6: grant starts the break
    step(0, 0, 1, 4'b1111, 1);
    step(0, 0, 1, 4'b1111, 1);
    // R7: grant ends, then R9: locked despite ticks
    step(0, 1, 1, 4'b1111, 0);
    step(0, 1, 1, 4'b1111, 0);
    step(0, 1, 1, 4'b1111, 0);
    // R8: flag drop re-arms, then a fresh post is withdrawn
    step(0, 0, 0, 4'b1111, 0);
    step(0, 1, 1, 4'b1111, 0);
    step(0, 0, 0, 4'b1111, 0);
    step(0, 0, 0, 4'b1111, 0);
    // R1: clear in mid-request
    step(0, 1, 1, 4'b1111, 0);
    step(1, 0, 1, 4'b1111, 0);
    step(0, 0, 1, 4'b1111, 0);
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 97) == 0, ($urandom % 3) == 0, ($urandom % 6) != 0,
           NLEV'($urandom), ($urandom % 3) == 0);
    end
    step(0, 0, 0, '1, 0);
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end
endmodule